// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch or conditional move goes ahead. It takes a condition selector and the four arithmetic flags: carry (C), zero (Z), sign (S) and overflow (O). It returns one bit that is high when the selected condition is met. The block is purely combinational. Flag generation and status-word storage live elsewhere.

Only the low four bits of the selector choose the condition, so the sixteen conditions form fixed complementary pairs. Each even selector tests a primitive term, and the following odd selector tests the inverse of that term. The exceptions are selector 14, which always holds, and selector 15, which never holds. Signed orderings are derived from the exclusive-OR of S and O.

Top module: `bceval`

## Requirements
- R1: Selector 0 yields Z and selector 1 yields NOT Z (equal, not equal).
- R2: Selector 2 yields C and selector 3 yields NOT C (unsigned higher-or-same, unsigned lower).
- R3: Selector 4 yields C AND NOT Z (unsigned higher), and selector 5 yields its inverse (unsigned lower-or-same).
- R4: Selector 6 yields NOT S (positive or zero) and selector 7 yields S (negative).
- R5: Selector 8 yields NOT (S XOR O) (signed greater-or-equal) and selector 9 yields S XOR O (signed less).
- R6: Selector 10 yields NOT ((S XOR O) OR Z) (signed greater) and selector 11 yields (S XOR O) OR Z (signed less-or-equal).
- R7: Selector 12 yields O and selector 13 yields NOT O.
- R8: Selector 14 yields 1 and selector 15 yields 0, whatever the flags are.
- R9: Selector bits above bit 3 have no effect on the output.
- R10: For every even selector from 0 to 12, the output under selector k+1 is the inverse of the output under selector k for the same flags.
- R11: The output follows any change of selector or flags with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_code | input | CODE_W (default 8) | Condition selector; only bits 3:0 are decoded |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| taken | output | 1 | High when the selected condition holds |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and `taken`. The bench changes the inputs one time unit after a rising edge and samples `taken` a few time units later, before the next edge. Each check therefore sees the response to the stimulus just applied, with no clock edge in between. A vector table covers the pairs and the upper-bit cases. An exhaustive sweep over all selectors and flag values then compares the output against a model written independently in the bench.

// File: rtl/bceval_pkg.sv
package bceval_pkg;

  localparam int unsigned SEL_W    = 4;
  localparam int unsigned NUM_SEL  = 1 << SEL_W;
  localparam int unsigned NUM_PAIR = NUM_SEL / 2;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic o;
  } flags_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_EQ  = 4'd0,  SEL_NE  = 4'd1,
    SEL_HS  = 4'd2,  SEL_LO  = 4'd3,
    SEL_HI  = 4'd4,  SEL_LS  = 4'd5,
    SEL_PZ  = 4'd6,  SEL_MI  = 4'd7,
    SEL_GE  = 4'd8,  SEL_LT  = 4'd9,
    SEL_GT  = 4'd10, SEL_LE  = 4'd11,
    SEL_OV  = 4'd12, SEL_NOV = 4'd13,
    SEL_ALW = 4'd14, SEL_NEV = 4'd15
  } sel_e;

  // Signed "less than" after a subtract: sign disagrees with overflow.
  function automatic logic signed_less(input flags_t f);
    return f.s ^ f.o;
  endfunction

  // Primitive (true-polarity) term of each pair; the odd member inverts it.
  // Pair 7 returns 1 so that its even member (selector 14) is "always".
  function automatic logic pair_term(input int unsigned pair, input flags_t f);
    logic t;
    case (pair)
      0:       t = f.z;
      1:       t = f.c;
      2:       t = f.c & ~f.z;
      3:       t = ~f.s;
      4:       t = ~signed_less(f);
      5:       t = ~(signed_less(f) | f.z);
      6:       t = f.o;
      default: t = 1'b1;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/bceval_terms.sv
module bceval_terms
  import bceval_pkg::*;
(
  input  flags_t              flags,
  output logic [NUM_PAIR-1:0] term
);

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    assign term[p] = pair_term(p, flags);
  end

endmodule

// File: rtl/bceval_table.sv
module bceval_table
  import bceval_pkg::*;
(
  input  logic [NUM_PAIR-1:0] term,
  output logic [NUM_SEL-1:0]  hold
);

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_entry
    assign hold[2*p]   = term[p];
    assign hold[2*p+1] = ~term[p];
  end

endmodule

// File: rtl/bceval_mux.sv
module bceval_mux
  import bceval_pkg::*;
(
  input  logic [NUM_SEL-1:0] hold,
  input  logic [SEL_W-1:0]   sel,
  output logic               pick
);

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (sel == SEL_W'(i)) pick = hold[i];
    end
  end

endmodule

// File: rtl/bceval.sv
module bceval
  import bceval_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic [CODE_W-1:0] cond_code,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_o,
  output logic              taken
);

  localparam int unsigned USED_W = (CODE_W < SEL_W) ? CODE_W : SEL_W;

  flags_t              flags;
  logic [SEL_W-1:0]    sel;
  logic [NUM_PAIR-1:0] term;
  logic [NUM_SEL-1:0]  hold;
  logic                sign_mismatch;

  assign flags = '{c: flag_c, z: flag_z, s: flag_s, o: flag_o};
  assign sel   = SEL_W'(cond_code[USED_W-1:0]);

  // Named event wire for the signed checks below.
  assign sign_mismatch = flag_s ^ flag_o;

  bceval_terms u_terms (.flags(flags), .term(term));
  bceval_table u_table (.term(term), .hold(hold));
  bceval_mux   u_mux   (.hold(hold), .sel(sel), .pick(taken));

  always_comb begin
    if (sel == SEL_EQ)  AST_EQUAL_ZERO:    assert (taken == flag_z);                        // R1
    if (sel == SEL_LO)  AST_LOWER_CARRY:   assert (taken == !flag_c);                       // R2
    if (sel == SEL_HI)  AST_HIGHER_UNS:    assert (taken == (flag_c && !flag_z));           // R3
    if (sel == SEL_MI)  AST_NEGATIVE:      assert (taken == flag_s);                        // R4
    if (sel == SEL_LT)  AST_SIGNED_LESS:   assert (taken == sign_mismatch);                 // R5
    if (sel == SEL_GT)  AST_SIGNED_GREATER: assert (taken == !(sign_mismatch || flag_z));   // R6
    if (sel == SEL_OV)  AST_OVERFLOW_SET:  assert (taken == flag_o);                        // R7
    if (sel == SEL_ALW) AST_ALWAYS_TRUE:   assert (taken);                                  // R8
    if (sel == SEL_NEV) AST_NEVER_TRUE:    assert (!taken);                                 // R8
  end

endmodule

// File: tb/bceval_test.sv
module bceval_test;

  localparam int CODE_W = 8;
  localparam int NVEC   = 22;

  // Entry layout: {selector[7:0], C, Z, S, O, expected}
  localparam logic [12:0] VEC [0:NVEC-1] = '{
    {8'h00, 4'b0100, 1'b1},  // R1
    {8'h00, 4'b0000, 1'b0},  // R1
    {8'h01, 4'b0100, 1'b0},  // R1
    {8'h02, 4'b1000, 1'b1},  // R2
    {8'h03, 4'b1000, 1'b0},  // R2
    {8'h04, 4'b1000, 1'b1},  // R3
    {8'h04, 4'b1100, 1'b0},  // R3
    {8'h05, 4'b1100, 1'b1},  // R3
    {8'h06, 4'b0010, 1'b0},  // R4
    {8'h07, 4'b0010, 1'b1},  // R4
    {8'h08, 4'b0011, 1'b1},  // R5
    {8'h09, 4'b0010, 1'b1},  // R5
    {8'h0A, 4'b0000, 1'b1},  // R6
    {8'h0A, 4'b0100, 1'b0},  // R6
    {8'h0B, 4'b0001, 1'b1},  // R6
    {8'h0C, 4'b0001, 1'b1},  // R7
    {8'h0D, 4'b0001, 1'b0},  // R7
    {8'h0E, 4'b0000, 1'b1},  // R8
    {8'h0F, 4'b1111, 1'b0},  // R8
    {8'h30, 4'b0100, 1'b1},  // R9
    {8'hFE, 4'b0000, 1'b1},  // R9
    {8'hAF, 4'b1111, 1'b0}   // R9
  };

  logic              clk = 1'b0;
  logic [CODE_W-1:0] cond_code = '0;
  logic              flag_c = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_o = 1'b0;
  logic              taken;
  int                n_checks = 0;
  int                n_fail   = 0;
  bit                done     = 1'b0;

  always #10 clk = ~clk;

  bceval #(.CODE_W(CODE_W)) uut (
    .cond_code(cond_code), .flag_c(flag_c), .flag_z(flag_z),
    .flag_s(flag_s), .flag_o(flag_o), .taken(taken)
  );

  // Independent model, phrased as comparisons rather than the pair table.
  function automatic logic model(input logic [3:0] k, input logic c, z, s, o);
    logic slt;
    slt = (s != o);
    case (k)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return c && !z;
      4'd5:  return !c || z;
      4'd6:  return !s;
      4'd7:  return s;
      4'd8:  return !slt;
      4'd9:  return slt;
      4'd10: return !slt && !z;
      4'd11: return slt || z;
      4'd12: return o;
      4'd13: return !o;
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] k);
    case (k)
      4'd0, 4'd1:   return "R1";
      4'd2, 4'd3:   return "R2";
      4'd4, 4'd5:   return "R3";
      4'd6, 4'd7:   return "R4";
      4'd8, 4'd9:   return "R5";
      4'd10, 4'd11: return "R6";
      4'd12, 4'd13: return "R7";
      default:      return "R8";
    endcase
  endfunction

  task automatic apply(input logic [CODE_W-1:0] k, input logic [3:0] f);
    @(posedge clk);
    #1;
    cond_code = k;
    {flag_c, flag_z, flag_s, flag_o} = f;
    #4;
  endtask

  task automatic check(input string req, input logic exp);
    n_checks++;
    if (taken !== exp) begin
      n_fail++;
      $display("FAIL %s: code=%02h czso=%b%b%b%b actual=%b expected=%b",
               req, cond_code, flag_c, flag_z, flag_s, flag_o, taken, exp);
    end
  endtask

  initial begin
    // Idle inputs (selector 0, flags clear): Z is 0 so nothing is taken.
    #5;
    check("R1", 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][12:5], VEC[i][4:1]);
      check(VEC[i][12:5] > 8'h0F ? "R9" : tag_of(VEC[i][8:5]), VEC[i][0]);
    end

    // Exhaustive sweep; the result is due in the cycle the inputs change (R11).
    for (int k = 0; k < 16; k++) begin
      for (int f = 0; f < 16; f++) begin
        apply(CODE_W'(k), 4'(f));
        check(tag_of(4'(k)), model(4'(k), f[3], f[2], f[1], f[0]));
      end
    end

    // Complement pairs under identical flags (R10).
    for (int p = 0; p < 7; p++) begin
      for (int f = 0; f < 16; f++) begin
        logic ev;
        apply(CODE_W'(2*p), 4'(f));
        ev = taken;
        apply(CODE_W'(2*p+1), 4'(f));
        check("R10", ~ev);
      end
    end

    // Upper selector bits swept with fixed low bits (R9).
    for (int u = 1; u < 16; u++) begin
      apply(CODE_W'({4'(u), 4'd4}), 4'b1000);
      check("R9", 1'b1);
      apply(CODE_W'({4'(u), 4'd11}), 4'b0000);
      check("R9", 1'b0);
    end

    // Flags change mid-cycle with no clock edge in between (R11).
    @(posedge clk);
    #1;
    cond_code = 8'h07; {flag_c, flag_z, flag_s, flag_o} = 4'b0000;
    #2;
    check("R11", 1'b0);
    flag_s = 1'b1;
    #2;
    check("R11", 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule